// File: doc/BRIEF.md
# Receive Descriptor Ring DMA Engine

This block moves received frames from a byte stream into system memory through a circular ring of descriptors. Each descriptor is four 32-bit words placed 16 bytes apart starting at a programmable ring base. Word 1 holds the address of a receive buffer and word 2 holds completion status. For each incoming frame the engine reads word 1 of the descriptor at its DMA index and stores the frame bytes into that buffer, one byte per write. It then performs a read-modify-write of word 2 to record the length and the done flag, and advances the DMA index modulo the ring size.

Software hands descriptors back by re-arming them and writing a CPU index, which names the descriptor it released most recently. The engine fills a descriptor only while its DMA index differs from the CPU index, so one descriptor always separates the producer from the consumer. When no descriptor is free, the engine accepts the whole frame, discards it and counts it. A small register port holds the ring base, ring size, CPU index, enable control, busy status, DMA index reset and drop count.

Top module: `rx_desc_dma`

## Requirements
- R1: After reset, the control register (index 4) reads zero, the DMA index (index 3) is 0, the CPU index (index 2) is ring maximum minus one, the ring size (index 1) is the ring maximum, the drop count (index 6) is 0, and `in_ready` is low.
- R2: Frame byte k goes to buffer address word1+k. The write is issued on the word-aligned address with byte strobe bit (address mod 4) set and the byte copied into every lane. The descriptor at index i sits at ring base + 16*i, and word 1 is at offset 0.
- R3: When a frame completes, word 2 (offset 4) is rewritten with bit 31 (done) set, bit 30 (last segment) set, the stored length in bits 29:16, and bits 15:0 kept from the value read back. This write happens only after the last data byte of the frame has been written.
- R4: After each completed frame, the DMA index advances by one and wraps to 0 when it reaches the programmed ring size.
- R5: A descriptor is filled only while the DMA index differs from the CPU index. Otherwise the whole frame is consumed, nothing is written to memory, the DMA index holds, and the drop count increments once.
- R6: A frame longer than the buffer size has only its first buffer-size bytes stored, and its recorded length equals the buffer size.
- R7: Control bit 2 enables reception, and bit 3 reads busy while a frame is in progress. While idle and disabled, `in_ready` stays low. Clearing enable in the middle of a frame lets that frame complete before busy falls.
- R8: Writing a value with bit 16 set to register index 5 returns the DMA index to 0.
- R9: Memory read data is taken one cycle after `mem_re`. The engine never asserts a read and a write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte |
| in_last | input | 1 | Marks the final byte of a frame |
| in_ready | output | 1 | Engine accepts the byte this cycle |
| mem_re | output | 1 | Memory read request |
| mem_we | output | 1 | Memory write request |
| mem_addr | output | ADDR_W | Word-aligned byte address |
| mem_be | output | 4 | Byte strobes for writes |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after mem_re |

## Verification
Frame lengths are swept from one byte to past the buffer size. Short lengths expose off-by-one errors in byte lanes and length fields, and lengths above the buffer separate correct truncation from overrun into the neighbouring buffer. The bench holds the ring full by withholding releases, which checks that exactly the gap rule decides dropping and that a dropped frame leaves memory untouched. A second sweep with a smaller programmed ring size checks that wrapping follows the register and not the maximum. Disabling the engine while idle is distinguished from disabling it mid-frame, and an index reset is checked by where the next frame lands.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;

    // completion word layout (word 2 of a descriptor)
    localparam int W2_LEN_W    = 14;
    localparam int DESC_SHIFT  = 4;   // 16-byte descriptor stride
    localparam int W1_OFFSET   = 0;
    localparam int W2_OFFSET   = 4;

    // control / index-reset bit positions
    localparam int CTRL_EN_BIT   = 2;
    localparam int CTRL_BUSY_BIT = 3;
    localparam int IDXRST_BIT    = 16;

    typedef struct packed {
        logic                done;
        logic                last_seg;
        logic [W2_LEN_W-1:0] len;
        logic [15:0]         keep;
    } rx_word2_t;

    typedef enum logic [2:0] {
        REG_BASE   = 3'd0,
        REG_COUNT  = 3'd1,
        REG_CPU    = 3'd2,
        REG_DMA    = 3'd3,
        REG_CTRL   = 3'd4,
        REG_IDXRST = 3'd5,
        REG_DROPS  = 3'd6
    } reg_sel_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_LOAD,
        S_DATA,
        S_DROP,
        S_CRD,
        S_CWR
    } rx_state_e;

    function automatic rx_word2_t make_word2(input logic [W2_LEN_W-1:0] len,
                                             input logic [15:0] low);
        rx_word2_t w;
        w.done     = 1'b1;
        w.last_seg = 1'b1;
        w.len      = len;
        w.keep     = low;
        return w;
    endfunction

    function automatic logic [3:0] lane_strobe(input logic [1:0] lane);
        return 4'b0001 << lane;
    endfunction

endpackage

// File: rtl/rxdma_regs.sv
module rxdma_regs
    import rxdma_pkg::*;
#(
    parameter int AW        = 32,
    parameter int MAX_DESC  = 256,
    parameter int IW        = 8,
    parameter int CNTW      = 9
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            reg_we,
    input  logic [2:0]      reg_addr,
    input  logic [31:0]     reg_wdata,
    output logic [31:0]     reg_rdata,
    input  logic            busy,
    input  logic [IW-1:0]   dma_idx,
    input  logic [31:0]     drops,
    output logic [AW-1:0]   ring_base,
    output logic [CNTW-1:0] ring_count,
    output logic [IW-1:0]   cpu_idx,
    output logic            enable,
    output logic            idx_rst
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ring_base  <= '0;
            ring_count <= CNTW'(MAX_DESC);
            cpu_idx    <= IW'(MAX_DESC - 1);
            enable     <= 1'b0;
        end else if (reg_we) begin
            case (reg_addr)
                REG_BASE:  ring_base  <= reg_wdata[AW-1:0];
                REG_COUNT: ring_count <= reg_wdata[CNTW-1:0];
                REG_CPU:   cpu_idx    <= reg_wdata[IW-1:0];
                REG_CTRL:  enable     <= reg_wdata[CTRL_EN_BIT];
                default: ;
            endcase
        end
    end

    assign idx_rst = reg_we && (reg_addr == REG_IDXRST) && reg_wdata[IDXRST_BIT];

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            REG_BASE:  reg_rdata = 32'(ring_base);
            REG_COUNT: reg_rdata = 32'(ring_count);
            REG_CPU:   reg_rdata = 32'(cpu_idx);
            REG_DMA:   reg_rdata = 32'(dma_idx);
            REG_CTRL: begin
                reg_rdata[CTRL_EN_BIT]   = enable;
                reg_rdata[CTRL_BUSY_BIT] = busy;
            end
            REG_DROPS: reg_rdata = drops;
            default:   reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/rxdma_engine.sv
module rxdma_engine
    import rxdma_pkg::*;
#(
    parameter int AW        = 32,
    parameter int IW        = 8,
    parameter int CNTW      = 9,
    parameter int BUF_BYTES = 2048
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            enable,
    input  logic            idx_rst,
    input  logic [AW-1:0]   ring_base,
    input  logic [CNTW-1:0] ring_count,
    input  logic [IW-1:0]   cpu_idx,
    input  logic            in_valid,
    input  logic [7:0]      in_data,
    input  logic            in_last,
    output logic            in_ready,
    output logic            mem_re,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [3:0]      mem_be,
    output logic [31:0]     mem_wdata,
    input  logic [31:0]     mem_rdata,
    output logic [IW-1:0]   dma_idx,
    output logic [31:0]     drops,
    output logic            busy
);

    localparam int CW = $clog2(BUF_BYTES + 1);

    rx_state_e       state;
    logic [AW-1:0]   buf_ptr;
    logic [CW-1:0]   cnt;
    logic [IW-1:0]   idx_q;
    logic [31:0]     drop_q;
    logic [IW-1:0]   idx_next;
    logic [AW-1:0]   desc_addr;
    logic [AW-1:0]   byte_addr;
    logic            has_free;
    logic            room;
    logic            take;
    rx_word2_t       w2;

    assign has_free  = (idx_q != cpu_idx);
    assign room      = (cnt < CW'(BUF_BYTES));
    assign in_ready  = (state == S_DATA) || (state == S_DROP);
    assign take      = in_valid && in_ready;
    assign desc_addr = ring_base + (AW'(idx_q) << DESC_SHIFT);
    assign byte_addr = buf_ptr + AW'(cnt);
    assign idx_next  = ((CNTW'(idx_q) + CNTW'(1)) >= ring_count) ? '0 : idx_q + IW'(1);
    assign w2        = make_word2(W2_LEN_W'(cnt), mem_rdata[15:0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= S_IDLE;
            buf_ptr <= '0;
            cnt     <= '0;
            drop_q  <= '0;
        end else begin
            case (state)
                S_IDLE: begin
                    if (enable && in_valid) begin
                        if (has_free) begin
                            state <= S_FETCH;
                        end else begin
                            state  <= S_DROP;
                            drop_q <= drop_q + 32'd1;
                        end
                    end
                end
                S_FETCH: state <= S_LOAD;
                S_LOAD: begin
                    buf_ptr <= mem_rdata[AW-1:0];
                    cnt     <= '0;
                    state   <= S_DATA;
                end
                S_DATA: begin
                    if (take) begin
                        if (room) cnt <= cnt + CW'(1);
                        if (in_last) state <= S_CRD;
                    end
                end
                S_DROP: if (take && in_last) state <= S_IDLE;
                S_CRD:  state <= S_CWR;
                S_CWR:  state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || idx_rst) idx_q <= '0;
        else if (state == S_CWR) idx_q <= idx_next;
    end

    always_comb begin
        mem_re    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_be    = 4'b0000;
        mem_wdata = '0;
        case (state)
            S_FETCH: begin
                mem_re   = 1'b1;
                mem_addr = desc_addr + AW'(W1_OFFSET);
            end
            S_DATA: begin
                mem_we    = in_valid && room;
                mem_addr  = {byte_addr[AW-1:2], 2'b00};
                mem_be    = lane_strobe(byte_addr[1:0]);
                mem_wdata = {4{in_data}};
            end
            S_CRD: begin
                mem_re   = 1'b1;
                mem_addr = desc_addr + AW'(W2_OFFSET);
            end
            S_CWR: begin
                mem_we    = 1'b1;
                mem_addr  = desc_addr + AW'(W2_OFFSET);
                mem_be    = 4'b1111;
                mem_wdata = w2;
            end
            default: ;
        endcase
    end

    assign dma_idx = idx_q;
    assign drops   = drop_q;
    assign busy    = (state != S_IDLE);

    // R9
    rw_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(mem_re && mem_we));

    // R6
    len_cap_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(BUF_BYTES));

    // R3
    cmpl_order_chk: assert property (@(posedge clk) disable iff (rst)
        (state == S_CWR) |-> ($past(state) == S_CRD));

    // R7
    busy_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> ($past(state) == S_CWR || $past(state) == S_DROP));

    // R8
    idxrst_chk: assert property (@(posedge clk) disable iff (rst)
        idx_rst |=> (dma_idx == '0));

    // R5
    drop_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (state == S_DROP) |-> (!mem_we && !mem_re && $stable(dma_idx)));

endmodule

// File: rtl/rx_desc_dma.sv
module rx_desc_dma
    import rxdma_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int MAX_DESC  = 256,
    parameter int BUF_BYTES = 2048
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    input  logic              in_last,
    output logic              in_ready,
    output logic              mem_re,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [3:0]        mem_be,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata
);

    localparam int IW   = (MAX_DESC > 1) ? $clog2(MAX_DESC) : 1;
    localparam int CNTW = $clog2(MAX_DESC + 1);

    logic [ADDR_W-1:0] ring_base;
    logic [CNTW-1:0]   ring_count;
    logic [IW-1:0]     cpu_idx;
    logic [IW-1:0]     dma_idx;
    logic [31:0]       drops;
    logic              enable;
    logic              idx_rst;
    logic              busy;

    rxdma_regs #(
        .AW(ADDR_W), .MAX_DESC(MAX_DESC), .IW(IW), .CNTW(CNTW)
    ) i_regs (
        .clk(clk), .rst(rst),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .busy(busy), .dma_idx(dma_idx), .drops(drops),
        .ring_base(ring_base), .ring_count(ring_count), .cpu_idx(cpu_idx),
        .enable(enable), .idx_rst(idx_rst)
    );

    rxdma_engine #(
        .AW(ADDR_W), .IW(IW), .CNTW(CNTW), .BUF_BYTES(BUF_BYTES)
    ) i_engine (
        .clk(clk), .rst(rst),
        .enable(enable), .idx_rst(idx_rst),
        .ring_base(ring_base), .ring_count(ring_count), .cpu_idx(cpu_idx),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
        .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .dma_idx(dma_idx), .drops(drops), .busy(busy)
    );

endmodule

// File: tb/test_rx_desc_dma.sv
module test_rx_desc_dma;

    localparam int AW    = 16;
    localparam int NDESC = 4;
    localparam int BUFB  = 16;
    localparam int RBASE = 'h100;
    localparam int BBASE = 'h200;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_last = 1'b0;
    logic        in_ready;
    logic        mem_re, mem_we;
    logic [AW-1:0] mem_addr;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;

    logic [31:0] mem [0:255];

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    rx_desc_dma #(.ADDR_W(AW), .MAX_DESC(NDESC), .BUF_BYTES(BUFB)) i_rx_desc_dma (
        .clk(clk), .rst(rst),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
        .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    always @(posedge clk) begin
        if (mem_we)
            for (int l = 0; l < 4; l++)
                if (mem_be[l]) mem[mem_addr[9:2]][8*l +: 8] <= mem_wdata[8*l +: 8];
        if (mem_re) mem_rdata <= mem[mem_addr[9:2]];
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 60000 && !finished) begin
            total = total + 1;
            bad = bad + 1;
            $display("FAIL watchdog: run did not finish, actual=%0d expected<60000 cycles", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic int bufaddr(input int d);
        return BBASE + d * 32;
    endfunction

    function automatic logic [15:0] lowpat(input int d);
        return 16'h5A00 + 16'(d);
    endfunction

    function automatic logic [7:0] fb(input int seed, input int k);
        return 8'((seed * 7 + k * 13 + 1) & 255);
    endfunction

    function automatic logic [7:0] rdbyte(input int a);
        return mem[a >> 2][8 * (a % 4) +: 8];
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wreg(input logic [2:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rreg(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic rearm(input int d);
        mem[(RBASE + 16 * d + 4) >> 2] = 32'h4000_0000 | 32'(lowpat(d));
        mem[(RBASE + 16 * d + 12) >> 2] = 32'h0;
        for (int w = 0; w < 8; w++) mem[(bufaddr(d) >> 2) + w] = 32'hEEEE_EEEE;
    endtask

    task automatic send_frame(input int len, input int seed, input int d, input int dis_at);
        bit dis_done = 0;
        for (int k = 0; k < len; k++) begin
            bit acc = 0;
            while (!acc) begin
                @(negedge clk);
                reg_we = 1'b0;
                reg_addr = 3'd4;
                in_valid = 1'b1; in_data = fb(seed, k); in_last = (k == len - 1);
                if (k == dis_at && !dis_done) begin
                    reg_we = 1'b1; reg_wdata = 32'h0; dis_done = 1;
                end
                #1;
                if (dis_at >= 0 && k == dis_at + 1 && !acc)
                    // R7: frame still in progress after enable cleared
                    chk(reg_rdata[3] == 1'b1 && reg_rdata[2] == 1'b0, "R7 busy held mid-frame",
                        reg_rdata[3:2], 2'b10);
                acc = in_ready;
                @(posedge clk);
            end
        end
        @(negedge clk);
        reg_we = 1'b0; in_valid = 1'b0; in_last = 1'b0;
        #1;
        // R3: completion must not appear before the descriptor update cycle
        chk(mem[(RBASE + 16 * d + 4) >> 2][31] == 1'b0, "R3 done not early",
            mem[(RBASE + 16 * d + 4) >> 2][31], 0);
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 50; i++) begin
            rreg(3'd4, v);
            if (v[3] == 1'b0) break;
        end
    endtask

    task automatic verify(input int d, input int len, input int seed, input int cnt_ring);
        int stored;
        int errs = 0;
        logic [31:0] w2, exp2, v;
        stored = (len > BUFB) ? BUFB : len;
        w2 = mem[(RBASE + 16 * d + 4) >> 2];
        exp2 = 32'hC000_0000 | (32'(stored) << 16) | 32'(lowpat(d));
        chk(w2 == exp2, (len > BUFB) ? "R6 capped word2" : "R3 word2", w2, exp2);
        for (int k = 0; k < 32; k++) begin
            logic [7:0] e;
            e = (k < stored) ? fb(seed, k) : 8'hEE;
            if (rdbyte(bufaddr(d) + k) != e) errs++;
        end
        chk(errs == 0, (len > BUFB) ? "R6 buffer bytes" : "R2 buffer bytes", errs, 0);
        rreg(3'd3, v);
        chk(v == 32'((d + 1) % cnt_ring), "R4 dma index", v, (d + 1) % cnt_ring);
    endtask

    initial begin
        logic [31:0] v;
        int d;
        int errs;
        for (int i = 0; i < 256; i++) mem[i] = 32'h0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset values
        rreg(3'd4, v); chk(v == 0, "R1 control", v, 0);
        rreg(3'd3, v); chk(v == 0, "R1 dma index", v, 0);
        rreg(3'd2, v); chk(v == NDESC - 1, "R1 cpu index", v, NDESC - 1);
        rreg(3'd1, v); chk(v == NDESC, "R1 ring size", v, NDESC);
        rreg(3'd6, v); chk(v == 0, "R1 drops", v, 0);
        chk(in_ready == 1'b0, "R1 in_ready", in_ready, 0);

        for (int i = 0; i < NDESC; i++) begin
            mem[(RBASE + 16 * i) >> 2] = 32'(bufaddr(i));
            rearm(i);
        end
        wreg(3'd0, RBASE);
        wreg(3'd4, 32'h4);

        // length sweep with steady release
        d = 0;
        for (int len = 1; len <= 20; len++) begin
            send_frame(len, len, d, -1);
            wait_idle();
            verify(d, len, len, NDESC);
            rearm(d);
            wreg(3'd2, 32'(d));
            d = (d + 1) % NDESC;
        end

        // fill until ring full (cpu holds 3, dma starts at 0)
        for (int i = 0; i < 3; i++) begin
            send_frame(5, 40 + i, d, -1);
            wait_idle();
            verify(d, 5, 40 + i, NDESC);
            d = (d + 1) % NDESC;
        end
        // R5: ring full, frame dropped
        send_frame(6, 50, 3, -1);
        wait_idle();
        rreg(3'd6, v); chk(v == 1, "R5 drop count", v, 1);
        rreg(3'd3, v); chk(v == 3, "R5 dma index held", v, 3);
        chk(mem[(RBASE + 48 + 4) >> 2] == (32'h4000_0000 | 32'(lowpat(3))), "R5 word2 untouched",
            mem[(RBASE + 52) >> 2], 32'h4000_0000 | 32'(lowpat(3)));
        chk(rdbyte(bufaddr(3)) == 8'hEE, "R5 buffer untouched", rdbyte(bufaddr(3)), 8'hEE);
        send_frame(1, 51, 3, -1);
        wait_idle();
        rreg(3'd6, v); chk(v == 2, "R5 second drop", v, 2);

        // release one and fill descriptor 3
        rearm(0);
        wreg(3'd2, 32'd0);
        send_frame(7, 52, 3, -1);
        wait_idle();
        verify(3, 7, 52, NDESC);
        rearm(1); rearm(2); rearm(3);
        wreg(3'd2, 32'd3);
        d = 0;

        // R7 disabled while idle
        wreg(3'd4, 32'h0);
        errs = 0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_data = 8'h11; in_last = 1'b1;
            #1 if (in_ready) errs++;
        end
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
        chk(errs == 0, "R7 no accept when disabled", errs, 0);
        rreg(3'd3, v); chk(v == 0, "R7 index held when disabled", v, 0);

        // R7 disabled mid-frame: frame completes
        wreg(3'd4, 32'h4);
        send_frame(8, 60, 0, 3);
        wait_idle();
        verify(0, 8, 60, NDESC);
        rreg(3'd4, v); chk(v == 0, "R7 idle and disabled after frame", v, 0);
        wreg(3'd4, 32'h4);
        rearm(0);
        wreg(3'd2, 32'd0);

        // R8 index reset
        wreg(3'd5, 32'h0001_0000);
        rreg(3'd3, v); chk(v == 0, "R8 index reset", v, 0);
        for (int i = 0; i < NDESC; i++) rearm(i);
        wreg(3'd2, 32'd3);
        send_frame(3, 70, 0, -1);
        wait_idle();
        verify(0, 3, 70, NDESC);

        // R4 wrap at a programmed ring size of 3
        wreg(3'd1, 32'd3);
        wreg(3'd5, 32'h0001_0000);
        for (int i = 0; i < NDESC; i++) rearm(i);
        wreg(3'd2, 32'd2);
        d = 0;
        for (int n = 0; n < 6; n++) begin
            send_frame(4 + n, 80 + n, d, -1);
            wait_idle();
            verify(d, 4 + n, 80 + n, 3);
            rearm(d);
            wreg(3'd2, 32'(d));
            d = (d + 1) % 3;
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule